// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Controller

This block collects sixteen single-cycle request pulses and turns them into one active-low interrupt request toward a processor. Sources 0 to 7 model internal functions and sources 8 to 15 model external lines. Every source has four bits: enable, pending, pass (the unmask bit) and in-service. A source that is not enabled ignores its pulses. A source that is pending but has its pass bit clear stays visible to polling software but never drives the request line.

Software has two ways to service requests. It can read the pending bits and clear them itself. It can also run a hardware acknowledge cycle. In that cycle the highest numbered eligible source wins, its pending bit drops, and a vector made from a base nibble and the source number is presented for one clock. An optional service mode keeps an in-service bit set for each accepted source. While that bit is set it holds back that source and every lower one until software clears it.

The block sits in a priority chain through an active-low enable input and an active-low enable output. It answers an acknowledge only when the upstream device lets it through. It lets the chain through to the next device only when it has nothing to request itself.

The acknowledge sequencer has three states:
- `ST_IDLE`: waits for an acknowledge. It moves to `ST_PRESENT` when an acknowledge can be accepted, and to `ST_HOLD` when an acknowledge arrives that it cannot accept.
- `ST_PRESENT`: drives the vector for one clock. It then moves to `ST_HOLD` if the acknowledge is still high, or back to `ST_IDLE` if it has dropped.
- `ST_HOLD`: waits for the acknowledge to drop, then returns to `ST_IDLE`.

A cycle with both select and acknowledge high is illegal. The sequencer stays in `ST_IDLE` and nothing is written.

Top module: `vic_chain`

## Requirements
- R1: After reset every enable, pending, pass and in-service bit reads 0, and the control byte reads 0. `irq_n` is 1 and `vec_valid` is 0.
- R2: A pulse on `req[i]` sets pending bit i at the next edge only if enable bit i is 1. Writing 0 to an enable bit also clears that source's pending bit at the same edge.
- R3: A pending source whose pass bit is 0 keeps `irq_n` at 1. `irq_n` is 0 whenever some eligible source exists and `ack` is 0. An eligible source is one that is pending, has pass = 1 and is not blocked by service mode.
- R4: A write to a pending or in-service byte clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R5: Priority is fixed, with source 15 the highest and source 0 the lowest. The vector is {control[7:4], winning source number[3:0]}.
- R6: A rising edge that sees `ack`=1, `sel`=0, `ein_n`=0 and an eligible source starts an accept:
  - the winner's pending bit clears at that edge;
  - `vec_valid`=1 with the vector for exactly the next cycle;
  - a new accept needs `ack` to return to 0 first.
- R7: `irq_n` is 1 in every cycle where `ack` is 1.
- R8: `eout_n` is 0 exactly when `ein_n` is 0 and no eligible source exists. An acknowledge while `ein_n` is 1 produces no vector and leaves pending bits unchanged.
- R9: With service mode on (control bit 0 = 1), an accept sets the winner's in-service bit. With service mode off, no in-service bit is ever set.
- R10: With service mode on, a set in-service bit k blocks every source numbered k or lower from being eligible. Higher sources still request. Clearing bit k releases the block.
- R11: A cycle with `sel`=1 and `ack`=1 is ignored:
  - no register is written;
  - no vector is produced;
  - `rdata` reads 0.
- R12: Address map:
  - `addr[3]`=1 selects the control byte. Its bits [7:4] hold the vector base and bit 0 holds the service mode flag; bits [3:1] read 0.
  - Otherwise `addr[2:1]` selects the register kind: 00 enable, 01 pending, 10 pass, 11 in-service.
  - `addr[0]` selects the source bank: 0 = sources 7..0, 1 = sources 15..8.
  - `rdata` is combinational while `sel`=1 and `ack`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 16 | Request pulses, one bit per source |
| sel | input | 1 | Register access select |
| we | input | 1 | Write strobe, qualified by `sel` |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| ack | input | 1 | Interrupt acknowledge |
| ein_n | input | 1 | Chain enable in, active low |
| irq_n | output | 1 | Interrupt request, active low |
| eout_n | output | 1 | Chain enable out, active low |
| vec_valid | output | 1 | Vector present this cycle |
| vec_data | output | 8 | Vector value |

## Verification
The hardest situation to reach is the service-mode block. Three conditions must hold at once: an in-service bit is set, new requests arrive both below and above it, and software then clears the bits one bank at a time. The stimulus builds this state in steps:
- it accepts source 5 in service mode;
- it pulses sources 3 and 5 again and confirms that `irq_n` stays high;
- it pulses source 9, which nests a second accept;
- it releases the two in-service bits one at a time and checks that the blocked source 5 wins next.

A separate sweep loads several multi-bit pending patterns and drains them through repeated acknowledges. The bench predicts the vector order from the highest set bit of what remains.

// File: rtl/vic_pkg.sv
package vic_pkg;
    parameter int NSRC   = 16;
    parameter int BANKS  = NSRC / 8;
    parameter int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;
    parameter int ADDR_W = BANK_W + 3;
    parameter int IDX_W  = $clog2(NSRC);

    typedef enum logic [1:0] {
        KIND_ENABLE = 2'd0,
        KIND_PEND   = 2'd1,
        KIND_PASS   = 2'd2,
        KIND_SVC    = 2'd3
    } reg_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PRESENT = 2'd1,
        ST_HOLD    = 2'd2
    } ack_state_e;
endpackage

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int N = 16,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] cand,
    output logic         any,
    output logic [W-1:0] idx
);
    // ascending scan: the last hit is the highest numbered source
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i]) begin
                any = 1'b1;
                idx = W'(i);
            end
        end
    end
endmodule

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
#(
    parameter int N     = NSRC,
    parameter int AW    = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic              ack,
    input  logic [AW-1:0]     addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [N-1:0]      req,
    input  logic [N-1:0]      take_oh,
    input  logic              svc_set,
    output logic [N-1:0]      en_q,
    output logic [N-1:0]      pend_q,
    output logic [N-1:0]      pass_q,
    output logic [N-1:0]      isr_q,
    output logic [7-$clog2(N):0] base_q,
    output logic              ism_q
);
    localparam int IW = $clog2(N);
    localparam int NB = N / 8;
    localparam int BW = (NB > 1) ? $clog2(NB) : 1;

    logic          wr_ok, ctrl_hit;
    reg_kind_e     kind;
    logic [IW-1:0] boff;
    logic [N-1:0]  lane, wide;
    logic [N-1:0]  en_d, pass_d, pend_d, isr_d, keep_pend, keep_svc;

    assign wr_ok    = sel && we && !ack;
    assign ctrl_hit = addr[AW-1];
    assign kind     = reg_kind_e'(addr[BW+1:BW]);
    assign boff     = (NB == 1) ? '0 : (IW'(addr[BW-1:0]) << 3);
    assign wide     = {NB{wdata}};

    always_comb begin
        for (int i = 0; i < N; i++) lane[i] = (IW'(i >> 3) == (boff >> 3));
    end

    always_comb begin
        en_d      = en_q;
        pass_d    = pass_q;
        keep_pend = '1;
        keep_svc  = '1;
        if (wr_ok && !ctrl_hit) begin
            unique case (kind)
                KIND_ENABLE: en_d      = (en_q & ~lane) | (wide & lane);
                KIND_PASS:   pass_d    = (pass_q & ~lane) | (wide & lane);
                KIND_PEND:   keep_pend = ~lane | wide;
                KIND_SVC:    keep_svc  = ~lane | wide;
            endcase
        end
        pend_d = ((pend_q & keep_pend & ~take_oh) | (req & en_q)) & en_d;
        isr_d  = (isr_q & keep_svc) | (svc_set ? take_oh : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            pass_q <= '0;
            pend_q <= '0;
            isr_q  <= '0;
            base_q <= '0;
            ism_q  <= 1'b0;
        end else begin
            en_q   <= en_d;
            pass_q <= pass_d;
            pend_q <= pend_d;
            isr_q  <= isr_d;
            if (wr_ok && ctrl_hit) begin
                base_q <= wdata[7:IW];
                ism_q  <= wdata[0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (sel && !ack) begin
            if (ctrl_hit) begin
                rdata = {base_q, {(IW-1){1'b0}}, ism_q};
            end else begin
                unique case (kind)
                    KIND_ENABLE: rdata = en_q[boff +: 8];
                    KIND_PEND:   rdata = pend_q[boff +: 8];
                    KIND_PASS:   rdata = pass_q[boff +: 8];
                    KIND_SVC:    rdata = isr_q[boff +: 8];
                endcase
            end
        end
    end

    AST_OFF_NEVER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~en_q) == '0); // R2
    AST_TAKE_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        ((take_oh != '0) && ((req & take_oh) == '0)) |=> ((pend_q & $past(take_oh)) == '0)); // R6
    AST_SVC_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        ((isr_q & ~$past(isr_q)) != '0) |-> $past(ism_q)); // R9
    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && ack) |=> ($stable(en_q) && $stable(pass_q) && $stable(base_q))); // R11
endmodule

// File: rtl/vic_ack_fsm.sv
module vic_ack_fsm
    import vic_pkg::*;
#(
    parameter int IW = IDX_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ack,
    input  logic            sel,
    input  logic            ein_n,
    input  logic            any,
    input  logic [IW-1:0]   idx,
    input  logic [7-IW:0]   base,
    input  logic            ism,
    output logic            take,
    output logic            svc_set,
    output logic            vec_valid,
    output logic [7:0]      vec_data
);
    ack_state_e st_q, st_d;
    logic [7:0] vec_q;
    logic       accept;

    assign accept = (st_q == ST_IDLE) && ack && !sel && !ein_n && any;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (ack && !sel) st_d = accept ? ST_PRESENT : ST_HOLD;
            ST_PRESENT: st_d = ack ? ST_HOLD : ST_IDLE;
            ST_HOLD:    if (!ack) st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            vec_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept) vec_q <= {base, idx};
        end
    end

    always_comb begin
        take      = accept;
        svc_set   = accept && ism;
        vec_valid = (st_q == ST_PRESENT);
        vec_data  = vec_valid ? vec_q : 8'h00;
    end

    AST_VEC_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid); // R6
    AST_VEC_LEGAL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(ack && !sel && !ein_n)); // R11
endmodule

// File: rtl/vic_chain.sv
module vic_chain
    import vic_pkg::*;
#(
    parameter int N_SRC = NSRC,
    parameter int AW    = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  req,
    input  logic              sel,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              ack,
    input  logic              ein_n,
    output logic              irq_n,
    output logic              eout_n,
    output logic              vec_valid,
    output logic [7:0]        vec_data
);
    localparam int IW = $clog2(N_SRC);

    logic [N_SRC-1:0] en_q, pend_q, pass_q, isr_q, blk, elig, take_oh;
    logic [7-IW:0]    base_q;
    logic             ism_q, any, take, svc_set;
    logic [IW-1:0]    win;

    vic_regs #(.N(N_SRC), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .ack(ack),
        .addr(addr), .wdata(wdata), .rdata(rdata), .req(req),
        .take_oh(take_oh), .svc_set(svc_set),
        .en_q(en_q), .pend_q(pend_q), .pass_q(pass_q), .isr_q(isr_q),
        .base_q(base_q), .ism_q(ism_q)
    );

    // service-mode block: any in-service bit at or above a source holds it back
    for (genvar i = 0; i < N_SRC; i++) begin : g_blk
        assign blk[i] = ism_q && (|isr_q[N_SRC-1:i]);
    end

    assign elig = pend_q & pass_q & ~blk;

    vic_prio #(.N(N_SRC), .W(IW)) u_prio (
        .cand(elig), .any(any), .idx(win)
    );

    vic_ack_fsm #(.IW(IW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ack(ack), .sel(sel), .ein_n(ein_n),
        .any(any), .idx(win), .base(base_q), .ism(ism_q),
        .take(take), .svc_set(svc_set),
        .vec_valid(vec_valid), .vec_data(vec_data)
    );

    assign take_oh = take ? (N_SRC'(1) << win) : '0;
    assign irq_n   = !(any && !ack);
    assign eout_n  = !(!ein_n && !any);

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> ((pend_q & pass_q) != '0)); // R3
    AST_CHAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !eout_n |-> (!ein_n && irq_n)); // R8
    AST_IRQ_OFF_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> irq_n); // R7
endmodule

// File: tb/vic_chain_bench.sv
`timescale 1ns/1ps
module vic_chain_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req = '0;
    logic        sel = 1'b0, we = 1'b0, ack = 1'b0, ein_n = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata, vec_data;
    logic        irq_n, eout_n, vec_valid;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    vic_chain u_vic_chain (
        .clk(clk), .rst_n(rst_n), .req(req), .sel(sel), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ack(ack), .ein_n(ein_n), .irq_n(irq_n),
        .eout_n(eout_n), .vec_valid(vec_valid), .vec_data(vec_data)
    );

    localparam logic [1:0] K_EN = 2'd0, K_PEND = 2'd1, K_PASS = 2'd2, K_SVC = 2'd3;
    localparam logic [3:0] A_CTRL = 4'b1000;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        step();
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic wr16(input logic [1:0] k, input logic [15:0] v);
        wr({1'b0, k, 1'b0}, v[7:0]);
        wr({1'b0, k, 1'b1}, v[15:8]);
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        sel = 1'b1; we = 1'b0; addr = a;
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic rd16(input logic [1:0] k, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd({1'b0, k, 1'b0}, lo);
        rd({1'b0, k, 1'b1}, hi);
        v = {hi, lo};
    endtask

    task automatic pulse(input logic [15:0] p);
        @(negedge clk);
        req = p;
        step();
        req = '0;
    endtask

    task automatic do_ack(output logic vv, output logic [7:0] vd,
                          output logic irq_in, output logic vv_after);
        @(negedge clk);
        ack = 1'b1;
        #1 irq_in = irq_n;
        step();
        vv = vec_valid; vd = vec_data;
        ack = 1'b0;
        step();
        vv_after = vec_valid;
    endtask

    function automatic int top_bit(input logic [15:0] v);
        int h = -1;
        for (int i = 0; i < 16; i++) if (v[i]) h = i;
        return h;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v16;
        logic [7:0]  v8, vd;
        logic        vv, irqa, vva;
        logic [15:0] pats [6];
        pats = '{16'h8001, 16'h0F0F, 16'h1234, 16'hA5A5, 16'hFFFF, 16'h0400};

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step();

        // R1 reset state
        for (int k = 0; k < 4; k++) begin
            rd16(k[1:0], v16);
            chk("R1 register clear", v16, 0);
        end
        rd(A_CTRL, v8);
        chk("R1 control clear", v8, 0);
        chk("R1 irq_n idle", irq_n, 1);
        chk("R1 vec_valid idle", vec_valid, 0);
        chk("R8 eout_n passes when quiet", eout_n, 0);

        // R12 control layout
        wr(A_CTRL, 8'h7F);
        rd(A_CTRL, v8);
        chk("R12 control readback", v8, 8'h71);
        wr(A_CTRL, 8'h00);

        // per-source sweep: R2 R3 R5 R6 R7
        for (int i = 0; i < 16; i++) begin
            logic [15:0] b;
            logic [7:0]  base;
            b = 16'(1) << i;
            base = 8'((15 - i) << 4);
            wr(A_CTRL, base);
            wr16(K_EN, 16'h0000);
            wr16(K_PASS, 16'h0000);
            pulse(b);
            rd16(K_PEND, v16);
            chk("R2 disabled pulse ignored", v16, 0);
            wr16(K_EN, b);
            pulse(b);
            rd16(K_PEND, v16);
            chk("R2 enabled pulse pends", v16, b);
            chk("R3 masked keeps irq_n high", irq_n, 1);
            wr16(K_PASS, b);
            chk("R3 unmasked drives irq_n", irq_n, 0);
            chk("R8 eout_n blocked by own request", eout_n, 1);
            do_ack(vv, vd, irqa, vva);
            chk("R7 irq_n high during ack", irqa, 1);
            chk("R6 vector valid", vv, 1);
            chk("R5 vector value", vd, base | 8'(i));
            chk("R6 vector lasts one cycle", vva, 0);
            rd16(K_PEND, v16);
            chk("R6 winner pending cleared", v16, 0);
        end

        // priority drain: R5
        wr(A_CTRL, 8'h50);
        wr16(K_EN, 16'hFFFF);
        wr16(K_PASS, 16'hFFFF);
        foreach (pats[p]) begin
            logic [15:0] rem;
            rem = pats[p];
            pulse(rem);
            rd16(K_PEND, v16);
            chk("R2 pattern pends", v16, rem);
            while (rem != 0) begin
                int h;
                h = top_bit(rem);
                do_ack(vv, vd, irqa, vva);
                chk("R5 priority order", {vv, vd}, {1'b1, 8'h50 | 8'(h)});
                rem &= ~(16'(1) << h);
            end
            chk("R3 drained irq_n high", irq_n, 1);
        end

        // masked sources skipped: R3
        pulse(16'hFFFF);
        wr16(K_PASS, 16'h0F0F);
        do_ack(vv, vd, irqa, vva);
        chk("R3 winner among unmasked", vd, 8'h5B);
        rd16(K_PEND, v16);
        chk("R3 masked stay pending", v16, 16'hF7FF);

        // R4 write-zero-to-clear
        wr({1'b0, K_PEND, 1'b0}, 8'h5A);
        rd16(K_PEND, v16);
        chk("R4 pending low clear", v16, 16'hF75A);
        wr({1'b0, K_PEND, 1'b1}, 8'h0F);
        rd16(K_PEND, v16);
        chk("R4 pending high clear", v16, 16'h075A);
        // R2 disabling clears pending
        wr({1'b0, K_EN, 1'b0}, 8'h00);
        rd16(K_PEND, v16);
        chk("R2 disable clears pending", v16, 16'h0700);
        wr16(K_PEND, 16'h0000);
        wr16(K_EN, 16'hFFFF);
        wr16(K_PASS, 16'hFFFF);

        // R8 chain
        @(negedge clk);
        ein_n = 1'b1;
        #1 chk("R8 eout_n follows blocked chain", eout_n, 1);
        pulse(16'h0004);
        do_ack(vv, vd, irqa, vva);
        chk("R8 no vector when chain blocked", vv, 0);
        rd16(K_PEND, v16);
        chk("R8 pending kept when chain blocked", v16, 16'h0004);
        ein_n = 1'b0;
        #1 chk("R8 eout_n held by own request", eout_n, 1);

        // R11 illegal cycle
        @(negedge clk);
        sel = 1'b1; we = 1'b1; ack = 1'b1; addr = {1'b0, K_EN, 1'b0}; wdata = 8'h00;
        #1 chk("R11 rdata zero in illegal cycle", rdata, 0);
        step();
        chk("R11 no vector from illegal cycle", vec_valid, 0);
        sel = 1'b0; we = 1'b0; ack = 1'b0;
        step();
        rd16(K_EN, v16);
        chk("R11 enable unchanged", v16, 16'hFFFF);
        rd16(K_PEND, v16);
        chk("R11 pending unchanged", v16, 16'h0004);
        do_ack(vv, vd, irqa, vva);
        chk("R11 normal ack afterwards", {vv, vd}, {1'b1, 8'h52});

        // R9 R10 service mode
        wr(A_CTRL, 8'h31);
        pulse(16'h0020);
        do_ack(vv, vd, irqa, vva);
        chk("R9 accept source 5", vd, 8'h35);
        rd16(K_SVC, v16);
        chk("R9 in-service set", v16, 16'h0020);
        pulse(16'h0008);
        chk("R10 lower source blocked", irq_n, 1);
        pulse(16'h0020);
        chk("R10 same source blocked", irq_n, 1);
        pulse(16'h0200);
        chk("R10 higher source requests", irq_n, 0);
        do_ack(vv, vd, irqa, vva);
        chk("R10 nested accept source 9", vd, 8'h39);
        rd16(K_SVC, v16);
        chk("R9 nested in-service", v16, 16'h0220);
        chk("R10 blocked after nest", irq_n, 1);
        wr({1'b0, K_SVC, 1'b1}, 8'h00);
        rd16(K_SVC, v16);
        chk("R4 in-service high clear", v16, 16'h0020);
        chk("R10 still blocked by 5", irq_n, 1);
        wr({1'b0, K_SVC, 1'b0}, 8'hDF);
        chk("R10 release on clear", irq_n, 0);
        do_ack(vv, vd, irqa, vva);
        chk("R10 released source 5 wins", vd, 8'h35);
        wr16(K_SVC, 16'h0000);
        wr(A_CTRL, 8'h30);
        do_ack(vv, vd, irqa, vva);
        chk("R9 mode off accept", vd, 8'h33);
        rd16(K_SVC, v16);
        chk("R9 mode off no in-service", v16, 0);
        rd16(K_PEND, v16);
        chk("R6 all drained", v16, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule